// File: doc/BRIEF.md
# QoS-Aware Read/Write Port Arbiter

This block sits in front of a memory command scheduler and chooses, every clock cycle, at most one command from a set of request ports. Each port has an independent read request line and write request line, each tagged with a 4-bit QoS value. The arbiter decides which direction (read or write) to serve and which port within that direction wins, then presents the choice as a registered one-hot grant with a direction flag.

Read QoS values are mapped to three classes: low-priority (0-3), video (4-11) and high-priority (12-15). Write QoS values fall into two classes: normal (0-7) and video (8-15). A video command that has waited for its programmed timeout is escalated. A port-direction that has aging enabled is escalated once it has waited its programmed aging count. Both escalations land at the same top level. A per-direction credit counter shapes when the arbiter leaves the current direction. Timeouts, aging values and aging enables are static configuration inputs that are sampled only while the block is idle or in reset.

A requester holds its request line until it sees its grant. The cycle in which the grant is shown, the arbiter ignores that port-direction, which gives the requester a cycle to drop or replace the command.

Top module: `qarb_top`

## Requirements
- R1: Read QoS 0-3 is the low-priority class, 4-11 the video read class, 12-15 the high-priority read class; write QoS 0-7 is normal, and 8-15 is the video write class.
- R2: Within the chosen direction the winner is chosen in this order: escalated before not escalated; then, for reads, high-priority class before other classes; then the larger QoS value; then round-robin, where the scan starts at the port after the last winner of that direction, and index 0 follows the highest index.
- R3: The grant is registered: a request present before a rising edge produces `gnt_valid`=1, a one-hot `gnt_port` (bit p = port p) and `gnt_write` (1 = write) after that edge. When no port-direction is eligible, `gnt_valid`=0 and `gnt_port`=0. At most one grant is given per cycle.
- R4: A port-direction whose grant is being shown is not eligible in that cycle, so a request held high is granted at most every other cycle.
- R5: While serving reads, the arbiter keeps reads if an escalated read exists and read credit is non-zero. Otherwise it moves to writes if an escalated write exists with write credit, or if read credit is zero while a write is pending with write credit, or if no read is pending and a write is pending.
- R6: While serving writes, the arbiter keeps writes if an escalated write exists with write credit. Otherwise it moves to reads if an escalated read exists with read credit, if a high-priority-class read is pending with read credit, if write credit is zero while a read is pending with read credit, or if no write is pending and a read is pending.
- R7: While serving reads with both directions pending, with read credit left and nothing escalated, a read is granted.
- R8: An eligible video-class command is escalated once it has been eligible without a grant for the programmed video timeout number of cycles. A timeout of 0 escalates it in the first cycle. The count restarts when the command is granted or stops being an eligible video command.
- R9: With aging enabled, an eligible port-direction is escalated after the programmed aging count of unserved eligible cycles. With aging disabled it is never escalated by aging.
- R10: Each direction holds a credit count from 0 to CREDIT_MAX. A grant takes one credit from its own direction (floor 0) and returns one to the other direction (ceiling CREDIT_MAX). Without a grant, credits stay unchanged. Zero credit never blocks a grant when the other direction has nothing pending.
- R11: During and after reset there is no grant, the serving direction is read, and both credits are full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | NPORTS | Read request per port |
| rd_qos | input | NPORTS*4 | Read QoS, port p in bits [4p+3:4p] |
| wr_req | input | NPORTS | Write request per port |
| wr_qos | input | NPORTS*4 | Write QoS, port p in bits [4p+3:4p] |
| cfg_rd_vto | input | NPORTS*VTO_W | Video read timeout per port |
| cfg_wr_vto | input | NPORTS*VTO_W | Video write timeout per port |
| cfg_rd_age_en | input | NPORTS | Read aging enable per port |
| cfg_wr_age_en | input | NPORTS | Write aging enable per port |
| cfg_rd_age_init | input | NPORTS*AGE_W | Read aging count per port |
| cfg_wr_age_init | input | NPORTS*AGE_W | Write aging count per port |
| gnt_valid | output | 1 | A grant is shown this cycle |
| gnt_port | output | NPORTS | One-hot granted port |
| gnt_write | output | 1 | 1 = the grant is for a write |

## Verification
Every grant is due one clock edge after the request it answers. The bench therefore drives inputs on the falling edge and reads the grant on the next falling edge, with one rising edge between them. A video command with timeout T first wins at the (T+1)-th edge it has been eligible, and a port with aging count A first wins at the (A+1)-th such edge. The directed tests hold requests steady and compare each successive falling-edge sample against a grant sequence worked out from the masking and round-robin rules. Credit and direction effects are checked by placing vectors in a fixed order, so the bench knows each credit count before every vector.

// File: rtl/qarb_pkg.sv
package qarb_pkg;

  localparam int QOS_W = 4;

  // class thresholds (minimum QoS of each upper class)
  localparam logic [QOS_W-1:0] RD_VID_MIN  = 4'd4;
  localparam logic [QOS_W-1:0] RD_HIGH_MIN = 4'd12;
  localparam logic [QOS_W-1:0] WR_VID_MIN  = 4'd8;

  typedef enum logic [1:0] {
    RCLS_LOW  = 2'd0,
    RCLS_VID  = 2'd1,
    RCLS_HIGH = 2'd2
  } rd_class_e;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  function automatic rd_class_e rd_class(input logic [QOS_W-1:0] q);
    if (q >= RD_HIGH_MIN)     return RCLS_HIGH;
    else if (q >= RD_VID_MIN) return RCLS_VID;
    else                      return RCLS_LOW;
  endfunction

  function automatic logic wr_is_video(input logic [QOS_W-1:0] q);
    return (q >= WR_VID_MIN);
  endfunction

endpackage

// File: rtl/qarb_timer.sv
// Per port-direction escalation timers: video timeout and port aging.
module qarb_timer #(
  parameter int VTO_W = 11,
  parameter int AGE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             elig,
  input  logic             video,
  input  logic             taken,
  input  logic [VTO_W-1:0] vto,
  input  logic             age_en,
  input  logic [AGE_W-1:0] age_init,
  output logic             expired,
  output logic             aged
);

  logic [VTO_W-1:0] vcnt_q, vcnt_d;
  logic             vcnt_en;
  logic [AGE_W-1:0] acnt_q, acnt_d;
  logic             acnt_en;

  always_comb begin
    vcnt_d = vcnt_q;
    if (taken || !(elig && video))
      vcnt_d = '0;
    else if (vcnt_q < vto)
      vcnt_d = vcnt_q + 1'b1;
    vcnt_en = (vcnt_d != vcnt_q);

    acnt_d = acnt_q;
    if (taken || !elig || !age_en)
      acnt_d = '0;
    else if (acnt_q < age_init)
      acnt_d = acnt_q + 1'b1;
    acnt_en = (acnt_d != acnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vcnt_q <= '0;
    else if (vcnt_en) vcnt_q <= vcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acnt_q <= '0;
    else if (acnt_en) acnt_q <= acnt_d;
  end

  assign expired = elig & video & (vcnt_q >= vto);
  assign aged    = age_en & elig & (acnt_q >= age_init);

endmodule

// File: rtl/qarb_pick.sv
// Winner selection inside one direction: priority key then rotating scan.
module qarb_pick #(
  parameter int NPORTS = 3,
  parameter int QOS_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORTS-1:0]       elig,
  input  logic [NPORTS-1:0]       urgent,
  input  logic [NPORTS-1:0]       hiclass,
  input  logic [NPORTS*QOS_W-1:0] qos,
  input  logic                    advance,
  output logic                    any,
  output logic [NPORTS-1:0]       win
);

  localparam int KEY_W = QOS_W + 2;
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [KEY_W-1:0] key [NPORTS];
  logic [KEY_W-1:0] best;
  logic [IDX_W-1:0] rr_q, rr_d, win_idx;
  logic             found;

  for (genvar p = 0; p < NPORTS; p++) begin : g_key
    assign key[p] = {urgent[p], hiclass[p], qos[p*QOS_W +: QOS_W]};
  end

  always_comb begin
    best = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (elig[p] && (key[p] > best)) best = key[p];
    end

    found   = 1'b0;
    win_idx = '0;
    for (int off = 0; off < NPORTS; off++) begin
      int idx;
      idx = int'(rr_q) + off;
      if (idx >= NPORTS) idx = idx - NPORTS;
      if (!found && elig[idx] && (key[idx] == best)) begin
        found   = 1'b1;
        win_idx = IDX_W'(idx);
      end
    end

    win = '0;
    if (found) win[win_idx] = 1'b1;
    any = found;

    rr_d = rr_q;
    if (advance && found)
      rr_d = (win_idx == IDX_W'(NPORTS-1)) ? '0 : win_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr_q <= '0;
    else if (advance) rr_q <= rr_d;
  end

endmodule

// File: rtl/qarb_dir.sv
// Direction selection and per-direction credit counters.
module qarb_dir #(
  parameter int CREDIT_MAX = 4,
  localparam int CR_W = $clog2(CREDIT_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_any,
  input  logic            wr_any,
  input  logic            rd_urg_any,
  input  logic            wr_urg_any,
  input  logic            rd_hi_any,
  output logic            sel_wr,
  output logic            fire,
  output logic            cur_wr,
  output logic [CR_W-1:0] rd_credit,
  output logic [CR_W-1:0] wr_credit
);

  import qarb_pkg::*;

  localparam logic [CR_W-1:0] CR_FULL = CR_W'(CREDIT_MAX);

  dir_e            cur_q, cur_d, sel;
  logic            cur_en;
  logic [CR_W-1:0] rcr_q, rcr_d, wcr_q, wcr_d;
  logic            cr_en;
  logic            rd_cr, wr_cr;

  always_comb begin
    rd_cr = (rcr_q != '0);
    wr_cr = (wcr_q != '0);

    if (cur_q == DIR_RD) begin
      if (rd_urg_any && rd_cr)             sel = DIR_RD;
      else if (wr_urg_any && wr_cr)        sel = DIR_WR;
      else if (!rd_cr && wr_any && wr_cr)  sel = DIR_WR;
      else if (rd_any)                     sel = DIR_RD;
      else if (wr_any)                     sel = DIR_WR;
      else                                 sel = DIR_RD;
    end else begin
      if (wr_urg_any && wr_cr)             sel = DIR_WR;
      else if (rd_urg_any && rd_cr)        sel = DIR_RD;
      else if (rd_hi_any && rd_cr)         sel = DIR_RD;
      else if (!wr_cr && rd_any && rd_cr)  sel = DIR_RD;
      else if (wr_any)                     sel = DIR_WR;
      else if (rd_any)                     sel = DIR_RD;
      else                                 sel = DIR_WR;
    end

    fire   = (sel == DIR_RD) ? rd_any : wr_any;
    cur_d  = fire ? sel : cur_q;
    cur_en = fire;

    rcr_d = rcr_q;
    wcr_d = wcr_q;
    if (fire) begin
      if (sel == DIR_RD) begin
        rcr_d = (rcr_q == '0) ? '0 : rcr_q - 1'b1;
        wcr_d = (wcr_q == CR_FULL) ? CR_FULL : wcr_q + 1'b1;
      end else begin
        wcr_d = (wcr_q == '0) ? '0 : wcr_q - 1'b1;
        rcr_d = (rcr_q == CR_FULL) ? CR_FULL : rcr_q + 1'b1;
      end
    end
    cr_en = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= DIR_RD;
    else if (cur_en) cur_q <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcr_q <= CR_FULL;
      wcr_q <= CR_FULL;
    end else if (cr_en) begin
      rcr_q <= rcr_d;
      wcr_q <= wcr_d;
    end
  end

  assign sel_wr    = (sel == DIR_WR);
  assign cur_wr    = (cur_q == DIR_WR);
  assign rd_credit = rcr_q;
  assign wr_credit = wcr_q;

endmodule

// File: rtl/qarb_top.sv
module qarb_top #(
  parameter int NPORTS     = 3,
  parameter int QOS_W      = 4,
  parameter int VTO_W      = 11,
  parameter int AGE_W      = 10,
  parameter int CREDIT_MAX = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORTS-1:0]       rd_req,
  input  logic [NPORTS*QOS_W-1:0] rd_qos,
  input  logic [NPORTS-1:0]       wr_req,
  input  logic [NPORTS*QOS_W-1:0] wr_qos,
  input  logic [NPORTS*VTO_W-1:0] cfg_rd_vto,
  input  logic [NPORTS*VTO_W-1:0] cfg_wr_vto,
  input  logic [NPORTS-1:0]       cfg_rd_age_en,
  input  logic [NPORTS-1:0]       cfg_wr_age_en,
  input  logic [NPORTS*AGE_W-1:0] cfg_rd_age_init,
  input  logic [NPORTS*AGE_W-1:0] cfg_wr_age_init,
  output logic                    gnt_valid,
  output logic [NPORTS-1:0]       gnt_port,
  output logic                    gnt_write
);

  import qarb_pkg::*;

  localparam int CR_W = $clog2(CREDIT_MAX + 1);

  logic              gnt_valid_q, gnt_valid_d;
  logic              gnt_write_q, gnt_write_d;
  logic [NPORTS-1:0] gnt_port_q, gnt_port_d;

  logic [NPORTS-1:0] rd_elig, wr_elig, rd_high, rd_vid, wr_vid;
  logic [NPORTS-1:0] rd_exp, wr_exp, rd_aged, wr_aged, rd_urg, wr_urg;
  logic [NPORTS-1:0] rd_win, wr_win, rd_take, wr_take;
  logic              rd_any, wr_any, sel_wr, fire, cur_wr;
  logic [CR_W-1:0]   rd_credit, wr_credit;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    // the port-direction whose grant is on the outputs sits out one cycle
    assign rd_elig[p] = rd_req[p] & ~(gnt_valid_q & gnt_port_q[p] & ~gnt_write_q);
    assign wr_elig[p] = wr_req[p] & ~(gnt_valid_q & gnt_port_q[p] &  gnt_write_q);

    assign rd_high[p] = (rd_class(rd_qos[p*QOS_W +: QOS_W]) == RCLS_HIGH);
    assign rd_vid[p]  = (rd_class(rd_qos[p*QOS_W +: QOS_W]) == RCLS_VID);
    assign wr_vid[p]  = wr_is_video(wr_qos[p*QOS_W +: QOS_W]);

    assign rd_take[p] = fire & ~sel_wr & rd_win[p];
    assign wr_take[p] = fire &  sel_wr & wr_win[p];

    qarb_timer #(.VTO_W(VTO_W), .AGE_W(AGE_W)) u_rd_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .elig     (rd_elig[p]),
      .video    (rd_vid[p]),
      .taken    (rd_take[p]),
      .vto      (cfg_rd_vto[p*VTO_W +: VTO_W]),
      .age_en   (cfg_rd_age_en[p]),
      .age_init (cfg_rd_age_init[p*AGE_W +: AGE_W]),
      .expired  (rd_exp[p]),
      .aged     (rd_aged[p])
    );

    qarb_timer #(.VTO_W(VTO_W), .AGE_W(AGE_W)) u_wr_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .elig     (wr_elig[p]),
      .video    (wr_vid[p]),
      .taken    (wr_take[p]),
      .vto      (cfg_wr_vto[p*VTO_W +: VTO_W]),
      .age_en   (cfg_wr_age_en[p]),
      .age_init (cfg_wr_age_init[p*AGE_W +: AGE_W]),
      .expired  (wr_exp[p]),
      .aged     (wr_aged[p])
    );

    assign rd_urg[p] = rd_exp[p] | rd_aged[p];
    assign wr_urg[p] = wr_exp[p] | wr_aged[p];
  end

  qarb_pick #(.NPORTS(NPORTS), .QOS_W(QOS_W)) u_rd_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig    (rd_elig),
    .urgent  (rd_urg),
    .hiclass (rd_high),
    .qos     (rd_qos),
    .advance (fire & ~sel_wr),
    .any     (rd_any),
    .win     (rd_win)
  );

  qarb_pick #(.NPORTS(NPORTS), .QOS_W(QOS_W)) u_wr_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig    (wr_elig),
    .urgent  (wr_urg),
    .hiclass ({NPORTS{1'b0}}),
    .qos     (wr_qos),
    .advance (fire & sel_wr),
    .any     (wr_any),
    .win     (wr_win)
  );

  qarb_dir #(.CREDIT_MAX(CREDIT_MAX)) u_dir (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_any     (rd_any),
    .wr_any     (wr_any),
    .rd_urg_any (|rd_urg),
    .wr_urg_any (|wr_urg),
    .rd_hi_any  (|(rd_elig & rd_high)),
    .sel_wr     (sel_wr),
    .fire       (fire),
    .cur_wr     (cur_wr),
    .rd_credit  (rd_credit),
    .wr_credit  (wr_credit)
  );

  always_comb begin
    gnt_valid_d = fire;
    gnt_write_d = fire & sel_wr;
    gnt_port_d  = '0;
    if (fire) gnt_port_d = sel_wr ? wr_win : rd_win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid_q <= 1'b0;
      gnt_write_q <= 1'b0;
      gnt_port_q  <= '0;
    end else begin
      gnt_valid_q <= gnt_valid_d;
      gnt_write_q <= gnt_write_d;
      gnt_port_q  <= gnt_port_d;
    end
  end

  assign gnt_valid = gnt_valid_q;
  assign gnt_port  = gnt_port_q;
  assign gnt_write = gnt_write_q;

endmodule

// File: rtl/qarb_chk.sv
module qarb_chk #(
  parameter int NPORTS     = 3,
  parameter int CREDIT_MAX = 4,
  localparam int CR_W = $clog2(CREDIT_MAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] rd_req,
  input logic [NPORTS-1:0] wr_req,
  input logic              gnt_valid,
  input logic [NPORTS-1:0] gnt_port,
  input logic              gnt_write,
  input logic              cur_wr,
  input logic [CR_W-1:0]   rd_credit,
  input logic [CR_W-1:0]   wr_credit
);

  localparam logic [CR_W-1:0] CR_FULL = CR_W'(CREDIT_MAX);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_port) && (gnt_valid == (gnt_port != '0))); // R3

  AST_RD_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_write) |-> (($past(rd_req) & gnt_port) != '0)); // R3

  AST_WR_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_write) |-> (($past(wr_req) & gnt_port) != '0)); // R3

  AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_req == '0) && (wr_req == '0)) |=> !gnt_valid); // R3

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> !(gnt_valid && (gnt_port == $past(gnt_port)) &&
                    (gnt_write == $past(gnt_write)))); // R4

  AST_DIR_FOLLOWS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (cur_wr == gnt_write)); // R5

  AST_CREDIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_credit <= CR_FULL) && (wr_credit <= CR_FULL)); // R10

  AST_RD_CREDIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_write) |->
      ((rd_credit == (($past(rd_credit) == '0) ? '0 : $past(rd_credit) - 1'b1)) &&
       (wr_credit == (($past(wr_credit) == CR_FULL) ? CR_FULL : $past(wr_credit) + 1'b1)))); // R10

  AST_WR_CREDIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_write) |->
      ((wr_credit == (($past(wr_credit) == '0) ? '0 : $past(wr_credit) - 1'b1)) &&
       (rd_credit == (($past(rd_credit) == CR_FULL) ? CR_FULL : $past(rd_credit) + 1'b1)))); // R10

  AST_CREDIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> ($stable(rd_credit) && $stable(wr_credit))); // R10

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!gnt_valid && !cur_wr &&
                               rd_credit == CR_FULL && wr_credit == CR_FULL); // R11
    end
  end

endmodule

bind qarb_top qarb_chk #(.NPORTS(NPORTS), .CREDIT_MAX(CREDIT_MAX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_req    (rd_req),
  .wr_req    (wr_req),
  .gnt_valid (gnt_valid),
  .gnt_port  (gnt_port),
  .gnt_write (gnt_write),
  .cur_wr    (cur_wr),
  .rd_credit (rd_credit),
  .wr_credit (wr_credit)
);

// File: tb/qarb_top_tb_top.sv
module qarb_top_tb_top;

  localparam int N   = 3;
  localparam int NV  = 12;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  rd_req, wr_req;
  logic [11:0]   rd_qos, wr_qos;
  logic [32:0]   cfg_rd_vto, cfg_wr_vto;
  logic [N-1:0]  cfg_rd_age_en, cfg_wr_age_en;
  logic [29:0]   cfg_rd_age_init, cfg_wr_age_init;
  logic          gnt_valid, gnt_write;
  logic [N-1:0]  gnt_port;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  qarb_top dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_req          (rd_req),
    .rd_qos          (rd_qos),
    .wr_req          (wr_req),
    .wr_qos          (wr_qos),
    .cfg_rd_vto      (cfg_rd_vto),
    .cfg_wr_vto      (cfg_wr_vto),
    .cfg_rd_age_en   (cfg_rd_age_en),
    .cfg_wr_age_en   (cfg_wr_age_en),
    .cfg_rd_age_init (cfg_rd_age_init),
    .cfg_wr_age_init (cfg_wr_age_init),
    .gnt_valid       (gnt_valid),
    .gnt_port        (gnt_port),
    .gnt_write       (gnt_write)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // {rd_req, wr_req, rd_qos, wr_qos, exp_valid, exp_port, exp_write}
  // Applied in order from reset; credits and rotation pointers carry across.
  localparam logic [34:0] VEC [NV] = '{
    {3'b001, 3'b000, 12'h000, 12'h000, 1'b1, 3'b001, 1'b0}, // lone read
    {3'b000, 3'b010, 12'h000, 12'h000, 1'b1, 3'b010, 1'b1}, // no read -> write
    {3'b001, 3'b100, 12'h002, 12'h300, 1'b1, 3'b100, 1'b1}, // low read does not pull
    {3'b001, 3'b100, 12'h00C, 12'h300, 1'b1, 3'b001, 1'b0}, // high read pulls back
    {3'b011, 3'b100, 12'h091, 12'h900, 1'b1, 3'b010, 1'b0}, // larger QoS wins
    {3'b111, 3'b000, 12'h555, 12'h000, 1'b1, 3'b100, 1'b0}, // rotation at 2
    {3'b111, 3'b000, 12'h555, 12'h000, 1'b1, 3'b001, 1'b0}, // rotation wraps to 0
    {3'b010, 3'b001, 12'h000, 12'h000, 1'b1, 3'b001, 1'b1}, // read credit gone
    {3'b100, 3'b010, 12'h300, 12'h080, 1'b1, 3'b010, 1'b1}, // stay on writes
    {3'b110, 3'b001, 12'hFF0, 12'h000, 1'b1, 3'b010, 1'b0}, // high reads, rotation 1
    {3'b001, 3'b010, 12'h000, 12'h0F0, 1'b1, 3'b001, 1'b0}, // reads preferred
    {3'b000, 3'b000, 12'h000, 12'h000, 1'b0, 3'b000, 1'b0}  // nothing pending
  };

  localparam string VTAG [NV] = '{
    "R3", "R5", "R6", "R1", "R2", "R2", "R2", "R5", "R6", "R6", "R7", "R3"
  };

  task automatic check(input string rq, input logic ev, input logic [N-1:0] ep,
                       input logic ew);
    checks++;
    if (gnt_valid !== ev || gnt_port !== ep || gnt_write !== ew) begin
      fails++;
      $display("FAIL %s: actual valid=%0b port=%b write=%0b expected valid=%0b port=%b write=%0b",
               rq, gnt_valid, gnt_port, gnt_write, ev, ep, ew);
    end
  endtask

  task automatic clear_req();
    rd_req = '0; wr_req = '0; rd_qos = '0; wr_qos = '0;
  endtask

  task automatic cfg_default();
    cfg_rd_vto      = {3{11'h7FF}};
    cfg_wr_vto      = {3{11'h7FF}};
    cfg_rd_age_en   = '0;
    cfg_wr_age_en   = '0;
    cfg_rd_age_init = '0;
    cfg_wr_age_init = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clear_req();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual run still active expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    clear_req();
    cfg_default();
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 in reset", 1'b0, 3'b000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset", 1'b0, 3'b000, 1'b0);

    // table walk: drive, sample one edge later, then one idle cycle
    for (int k = 0; k < NV; k++) begin
      logic [34:0] v;
      v = VEC[k];
      rd_req = v[34:32]; wr_req = v[31:29]; rd_qos = v[28:17]; wr_qos = v[16:5];
      @(negedge clk);
      check($sformatf("%s vector %0d", VTAG[k], k), v[4], v[3:1], v[0]);
      clear_req();
      @(negedge clk);
    end

    // R11 / R7: after reset the serving direction is read
    cfg_default();
    do_reset();
    rd_req = 3'b100; wr_req = 3'b001;
    @(negedge clk);
    check("R11 read direction after reset", 1'b1, 3'b100, 1'b0);
    clear_req();

    // R4 held request alternates; R10 zero read credit still granted
    do_reset();
    rd_req = 3'b001;
    for (int s = 1; s <= 9; s++) begin
      @(negedge clk);
      if (s <= 4)
        check($sformatf("R4 held request sample %0d", s), (s % 2) == 1,
              ((s % 2) == 1) ? 3'b001 : 3'b000, 1'b0);
      if (s == 9) check("R10 grant with zero credit", 1'b1, 3'b001, 1'b0);
    end
    clear_req();

    // R8 video read timeout of 3 on port 1 against two high reads
    cfg_default();
    cfg_rd_vto[21:11] = 11'd3;
    do_reset();
    rd_req = 3'b111; rd_qos = 12'hF4F;
    @(negedge clk); check("R2 high read rotation s1", 1'b1, 3'b001, 1'b0);
    @(negedge clk); check("R2 high read rotation s2", 1'b1, 3'b100, 1'b0);
    @(negedge clk); check("R8 not yet expired s3", 1'b1, 3'b001, 1'b0);
    @(negedge clk); check("R8 expired video read s4", 1'b1, 3'b010, 1'b0);
    clear_req();

    // R9 write aging count 2 on port 1
    cfg_default();
    cfg_wr_age_en = 3'b010;
    cfg_wr_age_init[19:10] = 10'd2;
    do_reset();
    wr_req = 3'b111; wr_qos = 12'hF0F;
    @(negedge clk); check("R9 aging s1", 1'b1, 3'b001, 1'b1);
    @(negedge clk); check("R9 aging s2", 1'b1, 3'b100, 1'b1);
    @(negedge clk); check("R9 aged port wins s3", 1'b1, 3'b010, 1'b1);
    clear_req();

    // R9 aging disabled: port 1 keeps losing
    cfg_wr_age_en = 3'b000;
    do_reset();
    wr_req = 3'b111; wr_qos = 12'hF0F;
    repeat (2) @(negedge clk);
    @(negedge clk); check("R9 aging disabled s3", 1'b1, 3'b001, 1'b1);
    clear_req();

    // R5 / R8 expired video write (timeout 0) pulls away from reads
    cfg_default();
    cfg_wr_vto[21:11] = 11'd0;
    do_reset();
    rd_req = 3'b001; rd_qos = 12'h00F; wr_req = 3'b010; wr_qos = 12'h080;
    @(negedge clk); check("R5 expired video write switches", 1'b1, 3'b010, 1'b1);
    clear_req();

    // R1 write QoS 7 is normal class, so no escalation
    do_reset();
    rd_req = 3'b001; rd_qos = 12'h00F; wr_req = 3'b010; wr_qos = 12'h070;
    @(negedge clk); check("R1 write QoS 7 not video", 1'b1, 3'b001, 1'b0);
    clear_req();
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule